// File: doc/BRIEF.md
# Prescaled pacer clock generator

This block turns the reference clock into a periodic one-cycle tick. An ADC or DAC conversion sequencer uses that tick as its conversion clock. The period is set by a single 16-bit timer register. That register holds two fields: a 4-bit exponent for a power-of-two prescaler, and an 8-bit divider field. The divider field stores the complement of the wanted count: it holds 255 minus N.

When the reference clock runs at 4 MHz, one tick period is 250 ns times the prescale factor times N. Software works out the field values from a period in nanoseconds; this block does not. The block ticks only while its enable input is high. Any register write, and any cycle with the enable low, returns both counters to their start state. Because of that, a fresh full period always comes before the next tick.

Top module: `pacer_clk_gen`

## Requirements
- R1: After reset the register reads 16'hF000: the upper byte is 8'hF0, and the prescale code and divider field are both zero.
- R2: A write stores bits 11:0 of the write data. The prescale code sits in bits 11:8 and the divider field in bits 7:0. Bits 15:12 always read as 1.
- R3: Prescale codes 0 and 1 both give a prescale factor P of 1. A code k from 2 to 15 gives P = 2^k.
- R4: With divider field D, the count is N = 255 - D. While the enable is held high, ticks repeat every P*N reference cycles.
- R5: A divider field of 8'hFF (N = 0) counts 256, so the period is P*256 cycles.
- R6: After the enable rises, the first tick appears on the output exactly P*N rising edges later. It is visible in the cycle that follows the (P*N)-th enabled edge.
- R7: The tick is one cycle wide whenever P*N is greater than 1. When P*N equals 1, the tick stays high on every enabled cycle.
- R8: While the enable is low, no tick is produced and both counters are held at their start state.
- R9: A register write returns both counters to their start state and produces no tick in the cycle that follows it. The next tick comes P*N edges after the write, using the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable for the pacer |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data |
| tick_o | output | 1 | Pacer tick, registered |

## Verification
The assertions assume that the register changes only through the write strobe. They also assume that the enable and write inputs are stable around the rising edge. With those assumptions, the checker can derive the period from the read port at any time. The bench changes every input only on the falling clock edge. It writes the register either while the enable is low or as a deliberate mid-run reload. The longest period it selects is 32768 cycles, so every wait for a tick stays bounded.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int unsigned PRE_W_DEF = 4;
  localparam int unsigned DIV_W_DEF = 8;
  localparam int unsigned REG_W_DEF = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_RELD  = 2'd2
  } pacer_mode_e;
endpackage

// File: rtl/pacer_cfg_reg.sv
module pacer_cfg_reg #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [DIV_W-1:0] div_o,
  output logic [DIV_W-1:0] div_nxt_o
);
  localparam int unsigned FLD_W = PRE_W + DIV_W;

  logic [FLD_W-1:0] fld_q;
  logic             unused_hi;

  assign unused_hi = ^wdata_i[REG_W-1:FLD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   fld_q <= '0;
    else if (wr_i) fld_q <= wdata_i[FLD_W-1:0];
  end

  assign pre_o     = fld_q[FLD_W-1:DIV_W];
  assign div_o     = fld_q[DIV_W-1:0];
  assign div_nxt_o = wr_i ? wdata_i[DIV_W-1:0] : fld_q[DIV_W-1:0];
  assign rdata_o   = {{(REG_W-FLD_W){1'b1}}, fld_q};
endmodule

// File: rtl/pacer_prescaler.sv
module pacer_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] code_i,
  output logic             stb_o
);
  localparam int unsigned CNT_W = (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // terminal count 2^k-1; codes 0 and 1 both divide by one
  for (genvar b = 0; b < CNT_W; b++) begin : g_term
    assign term[b] = (code_i >= PRE_W'(2)) && (32'(code_i) > b);
  end

  assign stb_o = !clr_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (stb_o)  cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pacer_divider.sv
module pacer_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] div_nxt_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  // load complement+1 so overflow comes after N strobes; field all-ones gives 2^DIV_W
  assign wrap = stb_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= div_nxt_i + 1'b1;
      tick_o <= 1'b0;
    end else begin
      tick_o <= wrap;
      if (wrap)       cnt_q <= div_i + 1'b1;
      else if (stb_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pacer_clk_gen.sv
module pacer_clk_gen #(
  parameter int unsigned PRE_W = pacer_pkg::PRE_W_DEF,
  parameter int unsigned DIV_W = pacer_pkg::DIV_W_DEF,
  parameter int unsigned REG_W = pacer_pkg::REG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre;
  logic [DIV_W-1:0] div, div_nxt;
  logic             clr, stb;

  assign clr = wr_i || !en_i;

  pacer_cfg_reg #(.PRE_W(PRE_W), .DIV_W(DIV_W), .REG_W(REG_W)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pre_o     (pre),
    .div_o     (div),
    .div_nxt_o (div_nxt)
  );

  pacer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .code_i (pre),
    .stb_o  (stb)
  );

  pacer_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .stb_i     (stb),
    .div_i     (div),
    .div_nxt_i (div_nxt),
    .tick_o    (tick_o)
  );
endmodule

// File: rtl/pacer_clk_gen_chk.sv
module pacer_clk_gen_chk #(
  parameter int unsigned PRE_W = 4,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned REG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             wr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             tick_o
);
  localparam int unsigned PER_W = (1 << PRE_W) + DIV_W;

  logic [PRE_W-1:0] pre;
  logic [DIV_W-1:0] fld;
  logic [PER_W-1:0] p_fac, n_cnt, period, gap_q;
  logic             hit_q, clr;

  assign pre    = rdata_o[PRE_W+DIV_W-1:DIV_W];
  assign fld    = rdata_o[DIV_W-1:0];
  assign p_fac  = (pre < PRE_W'(2)) ? PER_W'(1) : (PER_W'(1) << pre);
  assign n_cnt  = (fld == '1) ? (PER_W'(1) << DIV_W) : PER_W'({DIV_W{1'b1}} - fld);
  assign period = p_fac * n_cnt;
  assign clr    = wr_i || !en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      hit_q <= 1'b0;
    end else if (clr) begin
      gap_q <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= (gap_q + 1'b1 == period);
      gap_q <= (gap_q + 1'b1 == period) ? '0 : gap_q + 1'b1;
    end
  end

  a_r4_r6_tick_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o == hit_q);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && period != PER_W'(1)) |=> !tick_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
  a_r9_write_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !tick_o);
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rdata_o[PRE_W+DIV_W-1:0] == $past(wdata_i[PRE_W+DIV_W-1:0]));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rdata_o));
endmodule

bind pacer_clk_gen pacer_clk_gen_chk #(.PRE_W(PRE_W), .DIV_W(DIV_W), .REG_W(REG_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .tick_o  (tick_o)
);

// File: tb/pacer_clk_gen_tb.sv
module pacer_clk_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        tick;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pacer_clk_gen u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .wr_i    (wr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .tick_o  (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [15:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic int period_of(input int pre, input int n);
    int p = (pre < 2) ? 1 : (1 << pre);
    return p * ((n == 0) ? 256 : n);
  endfunction

  // edges until tick seen, bounded
  task automatic wait_tick(input int lim, output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!tick && cnt <= lim);
  endtask

  task automatic t_reset;
    chk(rdata == 16'hF000, "R1 reset value", rdata, 16'hF000);
    chk(tick == 1'b0, "R1 reset tick", tick, 0);
  endtask

  task automatic t_rw;
    reg_wr(16'h0ABC);
    chk(rdata == 16'hFABC, "R2 readback", rdata, 16'hFABC);
    reg_wr(16'h5FFF);
    chk(rdata == 16'hFFFF, "R2 upper ones", rdata, 16'hFFFF);
    reg_wr(16'hF000);
    chk(rdata == 16'hF000, "R2 clear", rdata, 16'hF000);
    chk(tick == 1'b0, "R8 no tick while idle", tick, 0);
  endtask

  task automatic t_period(input int pre, input int n, input string req);
    int exp = period_of(pre, n);
    int cnt;
    en = 1'b0;
    reg_wr({4'h0, 4'(pre), 8'(255 - n)});
    en = 1'b1;
    wait_tick(exp + 4, cnt);
    chk(cnt == exp, {req, " R6 first tick"}, cnt, exp);
    if (exp > 1) begin
      @(negedge clk);
      chk(tick == 1'b0, {req, " R7 width"}, tick, 0);
      wait_tick(exp + 4, cnt);
      chk(cnt + 1 == exp, {req, " R4 repeat period"}, cnt + 1, exp);
    end else begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(tick == 1'b1, {req, " R7 period one"}, tick, 1);
      end
    end
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_disable;
    int cnt;
    int seen = 0;
    reg_wr({8'h00, 8'(255 - 10)});
    en = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 0, "R8 quiet when disabled", seen, 0);
    en = 1'b1;
    wait_tick(20, cnt);
    chk(cnt == 10, "R8 restart full period", cnt, 10);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reload;
    int cnt;
    reg_wr({8'h00, 8'(255 - 20)});
    en = 1'b1;
    repeat (7) @(negedge clk);
    reg_wr({8'h00, 8'(255 - 6)});
    chk(tick == 1'b0, "R9 no tick after write", tick, 0);
    wait_tick(30, cnt);
    chk(cnt == 6, "R9 new period after write", cnt, 6);
    en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_period(0, 5, "R4 N5");
    t_period(1, 5, "R3 code1");
    t_period(2, 3, "R3 code2");
    t_period(4, 2, "R3 code4");
    t_period(0, 0, "R5 N0");
    t_period(3, 0, "R5 code3 N0");
    t_period(0, 1, "R7 unit");
    t_period(15, 1, "R3 code15");
    t_disable();
    t_reload();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule